// File: doc/BRIEF.md
# Sequential Tagged Prefetch Engine

This block generates next-line prefetches for one cache level. The cache raises a trigger in two cases: a demand access misses, or a demand access makes the first use of a block that an earlier prefetch brought in. Loads and stores both raise triggers, and the trigger port carries them the same way. Each trigger loads a small degree automaton. The automaton then offers the blocks that follow the trigger block in address order, one request per clock, on a valid/ready stream.

The number of requests per trigger comes from a fixed policy. A miss asks for one block and a first use asks for four. An external degree controller caps that number through the `max_degree` input, which is sampled in the trigger cycle. A cap of zero turns prefetching off. A trigger that arrives while a sequence is still running drops the rest of that sequence and starts again from the new block. The sequence ends early rather than wrap past the top of the address space.

The controller has two states. In IDLE it offers nothing. In ISSUE it offers `pf_addr` and holds it until `pf_ready` accepts it. The transitions are as follows:
- IDLE to ISSUE on a trigger whose granted degree is nonzero and whose block is not the last one.
- ISSUE to ISSUE when a restart trigger arrives, when a request is accepted and more remain, or while it is stalled.
- ISSUE to IDLE when the last granted request is accepted, when the next block would wrap, or when a trigger arrives with zero grant or on the last block.
- IDLE to IDLE in every other case.

Top module: `seq_prefetch_engine`

## Requirements
- R1: After reset `pf_valid` is low and stays low until a trigger arrives.
- R2: A trigger in cycle T with nonzero grant makes `pf_valid` high in cycle T+1, with `pf_addr` equal to the trigger address with its low 6 bits cleared, plus 64 (the block size).
- R3: `trig_first_use` = 0 marks a miss and requests degree 1. `trig_first_use` = 1 marks a first use and requests degree 4. The grant is the smaller of the request and `max_degree`, sampled in the trigger cycle, and exactly that many requests are accepted when no later trigger interrupts.
- R4: Each accepted request (`pf_valid` and `pf_ready` both high) is followed, if the sequence continues, by one whose address is 64 higher. At most one request is offered per cycle.
- R5: While `pf_valid` is high and `pf_ready` is low, with no trigger, `pf_valid` and `pf_addr` hold for the next cycle.
- R6: A trigger while a sequence is active discards the remainder and restarts from the new trigger block with the new grant.
- R7: A trigger with `max_degree` = 0 leaves `pf_valid` low in the following cycle and ends any active sequence.
- R8: The low 6 bits of `pf_addr` are zero whenever `pf_valid` is high.
- R9: No request wraps. A trigger on the last 64-byte block of the address space produces nothing, and a sequence stops after offering that last block.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| trig_valid | input | 1 | Trigger from a load or store miss or first use |
| trig_first_use | input | 1 | 0 = miss, 1 = first use of a prefetched block |
| trig_addr | input | 32 | Byte address of the triggering access |
| max_degree | input | 3 | Degree cap from the degree controller |
| pf_valid | output | 1 | Prefetch request valid |
| pf_addr | output | 32 | Block-aligned prefetch address |
| pf_ready | input | 1 | Downstream accepts the request |

## Verification
The assertions check the following on every cycle:
- the stall hold;
- block alignment;
- the 64-byte step between accepted requests;
- the absence of wrap;
- the start address after a trigger;
- the zero-cap shutdown;
- the bound on the remaining count.

Only the bench's scenarios can show that the whole sequence has the right length. This covers the per-kind degree and its cap, the abort-and-restart case, and the early end at the top block. The bench checks these against a reference model, cycle by cycle and by counting accepted handshakes.

// File: rtl/seqpf_pkg.sv
package seqpf_pkg;

    typedef enum logic [0:0] {
        ST_IDLE  = 1'b0,
        ST_ISSUE = 1'b1
    } seqpf_state_e;

endpackage

// File: rtl/seqpf_degree_sel.sv
module seqpf_degree_sel #(
    parameter int DEG_W    = 3,
    parameter int MISS_DEG = 1,
    parameter int USE_DEG  = 4
) (
    input  logic             first_use,
    input  logic [DEG_W-1:0] cap,
    output logic [DEG_W-1:0] grant
);
    localparam logic [DEG_W-1:0] REQ_MISS = DEG_W'(MISS_DEG);
    localparam logic [DEG_W-1:0] REQ_USE  = DEG_W'(USE_DEG);

    logic [DEG_W-1:0] request;

    always_comb begin
        request = first_use ? REQ_USE : REQ_MISS;
        grant   = (cap < request) ? cap : request;
    end

endmodule

// File: rtl/seqpf_addr_step.sv
module seqpf_addr_step #(
    parameter int ADDR_W = 32,
    parameter int OFF_W  = 6
) (
    input  logic [ADDR_W-1:0] addr_in,
    output logic [ADDR_W-1:0] blk_next,
    output logic              at_top
);
    localparam logic [ADDR_W:0]   BLK_INC  = (ADDR_W+1)'(1) << OFF_W;
    localparam logic [ADDR_W-1:0] OFF_MASK = (ADDR_W'(1) << OFF_W) - ADDR_W'(1);

    logic [ADDR_W:0] sum;

    always_comb begin
        sum      = {1'b0, addr_in} + BLK_INC;
        blk_next = sum[ADDR_W-1:0] & ~OFF_MASK;
        at_top   = sum[ADDR_W];
    end

endmodule

// File: rtl/seq_prefetch_engine.sv
module seq_prefetch_engine
    import seqpf_pkg::*;
#(
    parameter int ADDR_W    = 32,
    parameter int BLK_BYTES = 64,
    parameter int DEG_W     = 3,
    parameter int MISS_DEG  = 1,
    parameter int USE_DEG   = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              trig_valid,
    input  logic              trig_first_use,
    input  logic [ADDR_W-1:0] trig_addr,
    input  logic [DEG_W-1:0]  max_degree,
    output logic              pf_valid,
    output logic [ADDR_W-1:0] pf_addr,
    input  logic              pf_ready
);
    localparam int OFF_W = $clog2(BLK_BYTES);
    localparam int IDX_W = ADDR_W - OFF_W;
    localparam int MAX_REQ = (MISS_DEG > USE_DEG) ? MISS_DEG : USE_DEG;
    localparam logic [IDX_W-1:0] IDX_ONE  = IDX_W'(1);
    localparam logic [IDX_W-1:0] IDX_LAST = '1;
    localparam logic [DEG_W-1:0] LEFT_ONE = DEG_W'(1);

    seqpf_state_e     state_q, state_d;
    logic [ADDR_W-1:0] addr_q, addr_d;
    logic [DEG_W-1:0] left_q, left_d;

    logic [DEG_W-1:0]  grant;
    logic [ADDR_W-1:0] start_next, step_next;
    logic              start_top, step_top;

    seqpf_degree_sel #(
        .DEG_W    (DEG_W),
        .MISS_DEG (MISS_DEG),
        .USE_DEG  (USE_DEG)
    ) u_deg (
        .first_use (trig_first_use),
        .cap       (max_degree),
        .grant     (grant)
    );

    seqpf_addr_step #(.ADDR_W(ADDR_W), .OFF_W(OFF_W)) u_start (
        .addr_in  (trig_addr),
        .blk_next (start_next),
        .at_top   (start_top)
    );

    seqpf_addr_step #(.ADDR_W(ADDR_W), .OFF_W(OFF_W)) u_step (
        .addr_in  (addr_q),
        .blk_next (step_next),
        .at_top   (step_top)
    );

    // next-state logic
    always_comb begin
        state_d = state_q;
        addr_d  = addr_q;
        left_d  = left_q;
        if (trig_valid) begin
            if (grant != '0 && !start_top) begin
                state_d = ST_ISSUE;
                addr_d  = start_next;
                left_d  = grant;
            end else begin
                state_d = ST_IDLE;
                left_d  = '0;
            end
        end else begin
            unique case (state_q)
                ST_IDLE: begin
                end
                ST_ISSUE: begin
                    if (pf_ready) begin
                        if (left_q == LEFT_ONE || step_top) begin
                            state_d = ST_IDLE;
                            left_d  = '0;
                        end else begin
                            addr_d = step_next;
                            left_d = left_q - LEFT_ONE;
                        end
                    end
                end
                default: state_d = ST_IDLE;
            endcase
        end
    end

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            addr_q  <= '0;
            left_q  <= '0;
        end else begin
            state_q <= state_d;
            addr_q  <= addr_d;
            left_q  <= left_d;
        end
    end

    // outputs
    always_comb begin
        pf_valid = (state_q == ST_ISSUE);
        pf_addr  = addr_q;
    end

    a_r5_hold_stall: assert property (@(posedge clk) disable iff (!rst_n)
        (pf_valid && !pf_ready && !trig_valid) |=> (pf_valid && $stable(pf_addr)));

    a_r8_aligned: assert property (@(posedge clk) disable iff (!rst_n)
        pf_valid |-> (pf_addr[OFF_W-1:0] == '0));

    a_r4_step: assert property (@(posedge clk) disable iff (!rst_n)
        (pf_valid && pf_ready && !trig_valid) |=>
            (!pf_valid || pf_addr[ADDR_W-1:OFF_W] == $past(pf_addr[ADDR_W-1:OFF_W]) + IDX_ONE));

    a_r9_no_wrap: assert property (@(posedge clk) disable iff (!rst_n)
        (pf_valid && pf_ready && !trig_valid && pf_addr[ADDR_W-1:OFF_W] == IDX_LAST) |=> !pf_valid);

    a_r2_start: assert property (@(posedge clk) disable iff (!rst_n)
        (trig_valid && max_degree != '0 && trig_addr[ADDR_W-1:OFF_W] != IDX_LAST) |=>
            (pf_valid && pf_addr[ADDR_W-1:OFF_W] == $past(trig_addr[ADDR_W-1:OFF_W]) + IDX_ONE));

    a_r7_zero_cap: assert property (@(posedge clk) disable iff (!rst_n)
        (trig_valid && max_degree == '0) |=> !pf_valid);

    a_r3_left_bound: assert property (@(posedge clk) disable iff (!rst_n)
        pf_valid |-> (left_q != '0 && int'(left_q) <= MAX_REQ));

endmodule

// File: tb/seq_prefetch_engine_test.sv
module seq_prefetch_engine_test;
    localparam int CLK_PERIOD = 10;
    localparam int WATCHDOG   = 150000;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        tv = 1'b0;
    logic        tk = 1'b0;
    logic [31:0] ta = '0;
    logic [2:0]  md = '0;
    logic        rdy = 1'b0;
    logic        pf_valid;
    logic [31:0] pf_addr;

    int checks = 0;
    int fails  = 0;
    int n_hs   = 0;
    string cur_tag = "R1";

    logic        m_act = 1'b0;
    logic [31:0] m_addr = '0;
    int          m_rem = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    seq_prefetch_engine uut (
        .clk            (clk),
        .rst_n          (rst_n),
        .trig_valid     (tv),
        .trig_first_use (tk),
        .trig_addr      (ta),
        .max_degree     (md),
        .pf_valid       (pf_valid),
        .pf_addr        (pf_addr),
        .pf_ready       (rdy)
    );

    function automatic int grant_of(logic first_use, logic [2:0] cap);
        int req = first_use ? 4 : 1;
        return (int'(cap) < req) ? int'(cap) : req;
    endfunction

    task automatic check(input logic ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic tick();
        logic        hs = m_act && rdy;
        logic [32:0] nxt;
        int          g;
        if (hs) n_hs++;
        if (tv) begin
            nxt = {1'b0, ta & ~32'h3F} + 33'h40;
            g   = grant_of(tk, md);
            if (nxt[32] || g == 0) begin
                m_act = 1'b0;
            end else begin
                m_act  = 1'b1;
                m_addr = nxt[31:0];
                m_rem  = g;
            end
        end else if (hs) begin
            nxt = {1'b0, m_addr} + 33'h40;
            if (m_rem == 1 || nxt[32]) m_act = 1'b0;
            else begin
                m_addr = nxt[31:0];
                m_rem--;
            end
        end
        @(negedge clk);
        check(pf_valid === m_act && (!m_act || pf_addr === m_addr), cur_tag,
              {31'b0, pf_valid, pf_addr}, {31'b0, m_act, m_addr});
    endtask

    task automatic burst(input logic kind, input logic [31:0] addr, input logic [2:0] cap,
                         input int exp_n, input string tag);
        cur_tag = tag;
        n_hs = 0;
        tv = 1'b1; tk = kind; ta = addr; md = cap; rdy = 1'b1;
        tick();
        tv = 1'b0;
        for (int i = 0; i < 8; i++) tick();
        check(n_hs == exp_n, tag, 64'(n_hs), 64'(exp_n));
    endtask

    initial begin
        int cyc = 0;
        while (cyc < WATCHDOG) begin
            @(posedge clk);
            cyc++;
        end
        fails++;
        checks++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        void'($urandom(32'd20240917));
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R1: reset state and quiet idle
        cur_tag = "R1";
        check(pf_valid === 1'b0, "R1", 64'(pf_valid), 64'd0);
        for (int i = 0; i < 3; i++) tick();

        burst(1'b0, 32'h0000_1234, 3'd7, 1, "R3 miss degree 1");
        burst(1'b1, 32'h0000_2010, 3'd7, 4, "R3 first-use degree 4");
        burst(1'b1, 32'h0000_3000, 3'd2, 2, "R3 cap 2");
        burst(1'b1, 32'h0000_4000, 3'd0, 0, "R7 zero cap");
        burst(1'b1, 32'hFFFF_FFC5, 3'd4, 0, "R9 last block");
        burst(1'b1, 32'hFFFF_FF40, 3'd4, 2, "R9 stop at top");

        // R2 and R5: first offered address, then stall hold
        cur_tag = "R5 stall";
        tv = 1'b1; tk = 1'b1; ta = 32'h0000_5039; md = 3'd4; rdy = 1'b0;
        tick();
        check(pf_addr === 32'h0000_5040, "R2 start address", 64'(pf_addr), 64'h5040);
        tv = 1'b0;
        for (int i = 0; i < 4; i++) tick();
        check(pf_valid === 1'b1 && pf_addr === 32'h0000_5040, "R5 hold", 64'(pf_addr), 64'h5040);
        rdy = 1'b1;
        tick();
        check(pf_addr === 32'h0000_5080, "R4 step", 64'(pf_addr), 64'h5080);

        // R6: restart mid-sequence
        cur_tag = "R6 restart";
        tv = 1'b1; tk = 1'b0; ta = 32'h0009_0000; md = 3'd7;
        tick();
        check(pf_addr === 32'h0009_0040, "R6 restart addr", 64'(pf_addr), 64'h90040);
        tv = 1'b0;
        n_hs = 0;
        for (int i = 0; i < 6; i++) tick();
        check(n_hs == 1, "R6 restart count", 64'(n_hs), 64'd1);

        // R7: zero-cap trigger ends an active sequence
        tv = 1'b1; tk = 1'b1; ta = 32'h0000_7000; md = 3'd4; rdy = 1'b0;
        tick();
        cur_tag = "R7 abort";
        tv = 1'b1; md = 3'd0;
        tick();
        check(pf_valid === 1'b0, "R7 abort", 64'(pf_valid), 64'd0);
        tv = 1'b0;
        tick();

        // random mix, R4 R8 checked by model each cycle
        cur_tag = "R4 R8 random";
        for (int i = 0; i < 4000; i++) begin
            tv  = ($urandom_range(0, 4) == 0);
            tk  = 1'($urandom_range(0, 1));
            ta  = ($urandom_range(0, 7) == 0) ? (32'hFFFF_FE00 | 32'($urandom_range(0, 511)))
                                               : $urandom;
            md  = 3'($urandom_range(0, 7));
            rdy = ($urandom_range(0, 9) < 7);
            tick();
            if (pf_valid)
                check(pf_addr[5:0] == 6'd0, "R8 aligned", 64'(pf_addr), 64'(pf_addr & ~32'h3F));
        end
        tv = 1'b0;
        rdy = 1'b1;
        for (int i = 0; i < 6; i++) tick();

        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

endmodule